// File: doc/BRIEF.md
# SPI Serial Clock and Chip-Select Timing Generator

This block produces the serial clock and the chip-select framing for an SPI master. It runs from a fast core clock and takes all of its timing from counts that software sets up. The counts are the high and low phase widths of the serial clock, the lead time from select to the first clock edge, the trail time after the last bit period, and the minimum gap between two bursts. Mode inputs choose the clock idle level, the edge that carries data (clock phase), the level at which chip select is active, the edge used for sampling, and an extra sampling delay of up to seven core clocks.

A one-cycle start request begins one continuous burst of a programmed number of bit periods. It is accepted only while the block is idle, and the block returns to idle once the gap after chip-select release has run out. While the burst runs, the block gives a data shifter three things:
- a launch strobe, marking when to drive out the next bit;
- a sample strobe, marking when to capture the incoming bit;
- a phase flag, marking the second half of each bit period.

The configuration inputs must stay stable from the start request until the block is idle again.

Top module: `spi_tgen`

## Requirements
- R1: After reset, and whenever no burst is running, chip select is inactive, `sck` equals `cpol`, and `launch`, `sample` and `phase` are 0.
- R2: A start request that is accepted in cycle c makes chip select active from cycle c+1. `sck` then stays at `cpol` for `cs_lead_m1`+1 cycles before the first clock edge.
- R3: In each bit period `sck` spends `sck_hi_m1`+1 cycles high and `sck_lo_m1`+1 cycles low. The first half of the period is at the level opposite `cpol`, so one period lasts (`sck_hi_m1`+1)+(`sck_lo_m1`+1) cycles.
- R4: `launch` pulses for one cycle at the second edge of each bit period when `cpha`=0, and at the first edge when `cpha`=1. The first edge is the cycle in which `sck` leaves `cpol`; the second edge is the cycle in which it returns.
- R5: `cs` is driven high for active when `cs_active_high`=1, and low for active when `cs_active_high`=0.
- R6: When `sample_swap`=0, the undelayed sampling event is the edge opposite the launch edge. When `sample_swap`=1, it moves to the other edge of the bit period.
- R7: `sample` pulses `tick_delay` cycles (0 to 7) after the undelayed sampling event.
- R8: After the last bit period ends, chip select stays active for a further `cs_trail_m1`+1 cycles with `sck` at `cpol`, and is then released.
- R9: After release, chip select stays inactive for `cs_gap_m1`+1 cycles. A start request during that time is ignored. A start request in the next cycle is accepted, so chip select is inactive for at least `cs_gap_m1`+2 cycles.
- R10: A burst contains exactly `burst_bits_m1`+1 bit periods, back to back with no idle time between them.
- R11: `phase` is 1 exactly during the second half of each bit period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin a burst |
| burst_bits_m1 | input | BITS_W | Number of bit periods in the burst, minus one |
| sck_hi_m1 | input | CNT_W | Cycles with the serial clock high, minus one |
| sck_lo_m1 | input | CNT_W | Cycles with the serial clock low, minus one |
| cs_lead_m1 | input | CNT_W | Cycles from select to the first edge, minus one |
| cs_trail_m1 | input | CNT_W | Cycles from the end of the last bit to release, minus one |
| cs_gap_m1 | input | GAP_W | Minimum deselected cycles, minus one |
| cpol | input | 1 | Idle level of the serial clock |
| cpha | input | 1 | 0: data launched on the second edge; 1: on the first edge |
| cs_active_high | input | 1 | Chip-select polarity |
| sample_swap | input | 1 | Move sampling to the opposite edge |
| tick_delay | input | DLY_W | Extra core cycles before the sample strobe |
| sck | output | 1 | Serial clock |
| cs | output | 1 | Chip select |
| launch | output | 1 | Strobe: drive the next bit |
| sample | output | 1 | Strobe: capture the incoming bit |
| phase | output | 1 | High during the second half of each bit period |

## Verification
The assertions check properties that hold in every cycle:
- `launch` and any departure of `sck` from `cpol` happen only while chip select is active;
- no clock edge coincides with select or release;
- chip select is never reasserted in the cycle right after release;
- `launch` falls in the half of the bit period that `cpha` calls for.

The exact counts come only from the bench scenarios, which compare each cycle against arithmetic expectations. These counts cover the lead, half-period, trail and gap lengths, the number of bit periods, where `sample` falls after the swap and the tick delay, and a start request being dropped during the gap.

// File: rtl/spi_tgen_pkg.sv
package spi_tgen_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_LEAD   = 3'd1,
        ST_FIRST  = 3'd2,
        ST_SECOND = 3'd3,
        ST_TRAIL  = 3'd4,
        ST_GAP    = 3'd5
    } tgen_st_e;

endpackage

// File: rtl/spi_tgen_delay.sv
module spi_tgen_delay #(
    parameter int DLY_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pulse_in,
    input  logic [DLY_W-1:0] tick,
    output logic             pulse_out
);
    localparam int DMAX = (1 << DLY_W) - 1;

    logic [DMAX-1:0] sr_d, sr_q;

    generate
        if (DMAX > 1) begin : g_multi
            always_comb sr_d = {sr_q[DMAX-2:0], pulse_in};
        end else begin : g_single
            always_comb sr_d = pulse_in;
        end
    endgenerate

    always_comb begin
        if (tick == '0) pulse_out = pulse_in;
        else            pulse_out = sr_q[DLY_W'(tick - 1'b1)];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end
endmodule

// File: rtl/spi_tgen_seq.sv
module spi_tgen_seq #(
    parameter int CNT_W  = 16,
    parameter int GAP_W  = 8,
    parameter int BITS_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BITS_W-1:0] burst_bits_m1,
    input  logic [CNT_W-1:0]  sck_hi_m1,
    input  logic [CNT_W-1:0]  sck_lo_m1,
    input  logic [CNT_W-1:0]  cs_lead_m1,
    input  logic [CNT_W-1:0]  cs_trail_m1,
    input  logic [GAP_W-1:0]  cs_gap_m1,
    input  logic              cpol,
    output logic              sck_o,
    output logic              cs_act_o,
    output logic              lead_o,
    output logic              trail_o,
    output logic              phase_o
);
    import spi_tgen_pkg::*;

    typedef struct packed {
        tgen_st_e          st;
        logic [CNT_W-1:0]  cnt;
        logic [BITS_W-1:0] bits;
        logic              sck;
        logic              cs;
        logic              lead;
        logic              trail;
        logic              phase;
    } seq_s;

    localparam seq_s SEQ_RST = '0;

    seq_s q, d;
    logic [CNT_W-1:0] first_len, second_len;
    logic             cnt_zero;

    always_comb begin
        first_len  = cpol ? sck_lo_m1 : sck_hi_m1;
        second_len = cpol ? sck_hi_m1 : sck_lo_m1;
        cnt_zero   = (q.cnt == '0);

        d       = q;
        d.lead  = 1'b0;
        d.trail = 1'b0;
        d.cnt   = cnt_zero ? q.cnt : q.cnt - 1'b1;

        case (q.st)
            ST_IDLE: begin
                d.sck = cpol;
                d.cs  = 1'b0;
                if (start) begin
                    d.st   = ST_LEAD;
                    d.cnt  = cs_lead_m1;
                    d.bits = burst_bits_m1;
                    d.cs   = 1'b1;
                end
            end
            ST_LEAD: begin
                if (cnt_zero) begin
                    d.st   = ST_FIRST;
                    d.cnt  = first_len;
                    d.sck  = ~cpol;
                    d.lead = 1'b1;
                end
            end
            ST_FIRST: begin
                if (cnt_zero) begin
                    d.st    = ST_SECOND;
                    d.cnt   = second_len;
                    d.sck   = cpol;
                    d.trail = 1'b1;
                    d.phase = 1'b1;
                end
            end
            ST_SECOND: begin
                if (cnt_zero) begin
                    d.phase = 1'b0;
                    if (q.bits == '0) begin
                        d.st  = ST_TRAIL;
                        d.cnt = cs_trail_m1;
                    end else begin
                        d.bits = q.bits - 1'b1;
                        d.st   = ST_FIRST;
                        d.cnt  = first_len;
                        d.sck  = ~cpol;
                        d.lead = 1'b1;
                    end
                end
            end
            ST_TRAIL: begin
                if (cnt_zero) begin
                    d.st  = ST_GAP;
                    d.cnt = CNT_W'(cs_gap_m1);
                    d.cs  = 1'b0;
                end
            end
            ST_GAP: begin
                if (cnt_zero) d.st = ST_IDLE;
            end
            default: d = SEQ_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= SEQ_RST;
        else        q <= d;
    end

    assign sck_o    = (q.st == ST_IDLE) ? cpol : q.sck;
    assign cs_act_o = q.cs;
    assign lead_o   = q.lead;
    assign trail_o  = q.trail;
    assign phase_o  = q.phase;
endmodule

// File: rtl/spi_tgen.sv
module spi_tgen #(
    parameter int CNT_W  = 16,
    parameter int GAP_W  = 8,
    parameter int BITS_W = 8,
    parameter int DLY_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BITS_W-1:0] burst_bits_m1,
    input  logic [CNT_W-1:0]  sck_hi_m1,
    input  logic [CNT_W-1:0]  sck_lo_m1,
    input  logic [CNT_W-1:0]  cs_lead_m1,
    input  logic [CNT_W-1:0]  cs_trail_m1,
    input  logic [GAP_W-1:0]  cs_gap_m1,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              cs_active_high,
    input  logic              sample_swap,
    input  logic [DLY_W-1:0]  tick_delay,
    output logic              sck,
    output logic              cs,
    output logic              launch,
    output logic              sample,
    output logic              phase
);
    logic cs_act, lead, trail, raw_sample;

    spi_tgen_seq #(
        .CNT_W (CNT_W),
        .GAP_W (GAP_W),
        .BITS_W(BITS_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .burst_bits_m1(burst_bits_m1),
        .sck_hi_m1    (sck_hi_m1),
        .sck_lo_m1    (sck_lo_m1),
        .cs_lead_m1   (cs_lead_m1),
        .cs_trail_m1  (cs_trail_m1),
        .cs_gap_m1    (cs_gap_m1),
        .cpol         (cpol),
        .sck_o        (sck),
        .cs_act_o     (cs_act),
        .lead_o       (lead),
        .trail_o      (trail),
        .phase_o      (phase)
    );

    // data moves on the edge that cpha selects; capture uses the other one unless swapped
    assign launch     = cpha ? lead : trail;
    assign raw_sample = (cpha ^ sample_swap) ? trail : lead;
    assign cs         = cs_active_high ? cs_act : ~cs_act;

    spi_tgen_delay #(.DLY_W(DLY_W)) u_dly (
        .clk      (clk),
        .rst_n    (rst_n),
        .pulse_in (raw_sample),
        .tick     (tick_delay),
        .pulse_out(sample)
    );
endmodule

// File: rtl/spi_tgen_chk.sv
module spi_tgen_chk (
    input logic clk,
    input logic rst_n,
    input logic cpol,
    input logic cpha,
    input logic cs_active_high,
    input logic sck,
    input logic cs,
    input logic launch,
    input logic phase
);
    logic cs_on;
    assign cs_on = cs_active_high ? cs : ~cs;

    // R1: strobes only inside a selected burst
    a_r1_launch_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> cs_on);

    // R3: the clock leaves its idle level only while selected
    a_r3_toggle_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (sck != cpol) |-> cs_on);

    // R2: no clock edge in the cycle select is asserted
    a_r2_no_edge_at_select: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cs_on) && $stable(cs_active_high)) |-> (sck == cpol));

    // R8: release happens with the clock idle and outside a second half
    a_r8_quiet_release: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cs_on) && $stable(cs_active_high)) |-> (sck == cpol && !phase));

    // R9: select is never reasserted in the cycle after release
    a_r9_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cs_on) && $stable(cs_active_high)) |=> !cs_on);

    // R11: launch lands in the half that cpha calls for
    a_r11_launch_half_ph0: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && !cpha) |-> phase);
    a_r11_launch_half_ph1: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && cpha) |-> !phase);
endmodule

bind spi_tgen spi_tgen_chk u_chk (.*);

// File: tb/test_spi_tgen.sv
`timescale 1ns/1ps
module test_spi_tgen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  burst_bits_m1 = '0;
    logic [15:0] sck_hi_m1 = '0, sck_lo_m1 = '0, cs_lead_m1 = '0, cs_trail_m1 = '0;
    logic [7:0]  cs_gap_m1 = '0;
    logic        cpol = 1'b0, cpha = 1'b0, cs_active_high = 1'b0, sample_swap = 1'b0;
    logic [2:0]  tick_delay = '0;
    logic        sck, cs, launch, sample, phase;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    spi_tgen i_spi_tgen (
        .clk(clk), .rst_n(rst_n), .start(start), .burst_bits_m1(burst_bits_m1),
        .sck_hi_m1(sck_hi_m1), .sck_lo_m1(sck_lo_m1), .cs_lead_m1(cs_lead_m1),
        .cs_trail_m1(cs_trail_m1), .cs_gap_m1(cs_gap_m1), .cpol(cpol), .cpha(cpha),
        .cs_active_high(cs_active_high), .sample_swap(sample_swap),
        .tick_delay(tick_delay), .sck(sck), .cs(cs), .launch(launch),
        .sample(sample), .phase(phase)
    );

    task automatic chk(input bit ok, input string req, input int t, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s at t=%0d: actual=%0d expected=%0d", req, t, act, exp);
        end
    endtask

    function automatic int seg_s();  return int'(cs_lead_m1) + 1; endfunction
    function automatic int seg_p();  return int'(sck_hi_m1) + int'(sck_lo_m1) + 2; endfunction
    function automatic int seg_a();  return cpol ? int'(sck_lo_m1) + 1 : int'(sck_hi_m1) + 1; endfunction
    function automatic int seg_b();  return int'(burst_bits_m1) + 1; endfunction
    function automatic int rel_t();  return seg_s() + seg_b() * seg_p() + int'(cs_trail_m1) + 1; endfunction

    // undelayed sampling event at cycle v (R6)
    function automatic bit raw_smp(input int v);
        int u;
        if (v < seg_s() || v >= seg_s() + seg_b() * seg_p()) return 1'b0;
        u = (v - seg_s()) % seg_p();
        return (cpha ^ sample_swap) ? (u == seg_a()) : (u == 0);
    endfunction

    // compare cycles 0..len-1 of a burst, t=0 being the first selected cycle
    task automatic run_burst(input int len);
        for (int t = 0; t < len; t++) begin
            bit e_cs, e_sck, e_lau, e_smp, e_ph;
            int u;
            e_cs  = (t < rel_t());
            e_sck = cpol; e_lau = 0; e_ph = 0;
            if (t >= seg_s() && t < seg_s() + seg_b() * seg_p()) begin
                u = (t - seg_s()) % seg_p();
                if (u < seg_a()) e_sck = ~cpol; else e_ph = 1;
                e_lau = cpha ? (u == 0) : (u == seg_a());
            end
            e_smp = raw_smp(t - int'(tick_delay));
            chk(cs == (cs_active_high ? e_cs : ~e_cs), "R2 R5 R8 R10 cs", t, cs, cs_active_high ? e_cs : ~e_cs);
            chk(sck == e_sck, "R3 sck", t, sck, e_sck);
            chk(launch == e_lau, "R4 launch", t, launch, e_lau);
            chk(sample == e_smp, "R6 R7 sample", t, sample, e_smp);
            chk(phase == e_ph, "R11 phase", t, phase, e_ph);
            @(negedge clk);
        end
    endtask

    task automatic kick();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(cs == 1'b1, "R1 cs idle", 0, cs, 1);
        chk(sck == cpol, "R1 sck idle", 0, sck, cpol);
        chk({launch, sample, phase} == 3'b000, "R1 strobes idle", 0, {launch, sample, phase}, 0);
        cpol = 1'b1;
        @(negedge clk);
        chk(sck == 1'b1, "R1 sck follows cpol", 0, sck, 1);

        // sweep all mode bits and every tick delay over small counts
        for (int m = 0; m < 16; m++) begin
            for (int tk = 0; tk < 8; tk++) begin
                int idx = m * 8 + tk;
                cpol = m[0]; cpha = m[1]; sample_swap = m[2]; cs_active_high = m[3];
                tick_delay = 3'(tk);
                sck_hi_m1 = 16'(idx % 3);
                sck_lo_m1 = 16'((idx / 3) % 3);
                cs_lead_m1 = 16'(idx % 4);
                cs_trail_m1 = 16'((idx / 4) % 3);
                cs_gap_m1 = 8'(idx % 5);
                burst_bits_m1 = 8'(idx % 4);
                repeat (2) @(negedge clk);
                kick();
                run_burst(rel_t() + int'(cs_gap_m1) + 9);
            end
        end

        // wide counts and the full gap range
        cpol = 0; cpha = 1; sample_swap = 0; cs_active_high = 0; tick_delay = 3'd5;
        sck_hi_m1 = 16'd40; sck_lo_m1 = 16'd25; cs_lead_m1 = 16'd30; cs_trail_m1 = 16'd20;
        cs_gap_m1 = 8'd255; burst_bits_m1 = 8'd2;
        @(negedge clk);
        kick();
        run_burst(rel_t() + 264);

        // R9: start inside the gap is dropped, start right after it is taken
        for (int g = 0; g < 3; g++) begin
            cpol = g[0]; cpha = 0; sample_swap = 0; cs_active_high = 1; tick_delay = 0;
            sck_hi_m1 = 16'd1; sck_lo_m1 = 16'd2; cs_lead_m1 = 16'd1; cs_trail_m1 = 16'd0;
            cs_gap_m1 = 8'(g * 2); burst_bits_m1 = 8'd1;
            @(negedge clk);
            kick();
            run_burst(rel_t());
            start = 1'b1;
            chk(cs == 1'b0, "R9 released", rel_t(), cs, 0);
            @(negedge clk);
            start = 1'b0;
            for (int k = 1; k <= int'(cs_gap_m1) + 1; k++) begin
                chk(cs == 1'b0, "R9 start in gap ignored", rel_t() + k, cs, 0);
                if (k == int'(cs_gap_m1) + 1) start = 1'b1;
                @(negedge clk);
            end
            start = 1'b0;
            chk(cs == 1'b1, "R9 start after gap taken", 0, cs, 1);
            run_burst(rel_t() + int'(cs_gap_m1) + 3);
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule